// File: doc/BRIEF.md
# Thermal Step PWM Fan Controller

The block drives one fan PWM output whose duty follows a 16-bit temperature code. Five duty steps are defined: off, one quarter, one half, three quarters and full, all as fractions of a fixed PWM period. Each step above off has a rising threshold. Each step below full has a falling threshold. The gap between each pair gives hysteresis, so the fan does not toggle between two steps when the temperature sits near a single trip point. Threshold values are raw sensor codes, and no conversion to degrees is made in hardware. Level selection happens only at a PWM period boundary, so the output never shows a cut-short pulse.

Software can write a pulse width directly, which overrides the duty taken from the level. Whenever the applied duty changes, from either source, a settle timer starts. The timer's length is a parameter in clock cycles; in a real system it stands for a few seconds of fan spin-up. When the timer expires the block pulses a changed event. A raise of the step chosen by the hardware also gives a one-cycle temperature-up event. The block is held in reset until the run-enable control bit is 1. The threshold registers are not cleared by this hold, so they can be programmed first.

Temperature samples arrive on a valid/ready stream. Ready is high whenever the block is running, so there is no back-pressure during operation. While the block is held, ready is low and the producer must keep its sample. The last accepted sample stays in use until the next one is accepted.

Top module: `fan_step_ctrl`

## Requirements
- R1: While run_en is 0 the block is held: pwm_o stays low, level_o is 0 (off), tmp_ready is 0 and neither event pulses.
- R2: The PWM period is PWM_PERIOD clock cycles, reported unchanged on period_o. In each period pwm_o is high for width_o cycles. A software width larger than the period is clamped to the full period.
- R3: Level L (0 = off, 1 = quarter, 2 = half, 3 = three quarters, 4 = full) gives a high time of L*PWM_PERIOD/4 cycles.
- R4: thr_sel codes 0..3 hold the rising thresholds for levels 1..4. A code strictly above the rising threshold of a level higher than the current one raises the duty to the highest such level in one step. A code equal to a threshold does not trip it.
- R5: thr_sel codes 4..7 hold the falling thresholds for levels 0..3. A code strictly below the falling threshold of a lower level drops the duty to the lowest such level in one step. A code between the falling and rising thresholds keeps the current level.
- R6: level_o and width_o change only at the start of a PWM period.
- R7: evt_temp_up pulses for one cycle when the hardware raises the level. A drop of the level or a software width write does not pulse it.
- R8: evt_pwm_changed pulses exactly SETTLE_CYCLES cycles after a duty update is applied. A further update during the wait restarts the wait, so only one pulse follows.
- R9: A write on wid_we is applied at the next period boundary. It sets the high time directly whatever the current level, takes priority over the level evaluation at that boundary, and leaves level_o unchanged.
- R10: After reset the rising thresholds for levels 1..4 are 0x3000, 0x5000, 0x7000 and 0x9000. The falling thresholds for levels 0..3 are 0x0800 below the rising threshold of the next level up (0x2800, 0x4800, 0x6800, 0x8800). A write with thr_we replaces the selected threshold.
- R11: tmp_ready equals run_en. A sample is taken only when tmp_valid and tmp_ready are both high, and the last taken sample stays in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Soft run bit; 0 holds the block in reset |
| tmp_valid | input | 1 | Temperature sample valid |
| tmp_ready | output | 1 | Temperature sample accepted when high |
| tmp_code | input | TEMP_W | Raw temperature code |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 3 | Threshold select (0..3 rising, 4..7 falling) |
| thr_data | input | TEMP_W | Threshold value |
| wid_we | input | 1 | Software pulse-width write strobe |
| wid_data | input | WIDTH_W | Software pulse width in cycles |
| period_o | output | WIDTH_W | Fixed PWM period in cycles |
| width_o | output | WIDTH_W | Applied high time in cycles |
| level_o | output | 3 | Current hardware duty level |
| pwm_o | output | 1 | Fan PWM output |
| evt_temp_up | output | 1 | One-cycle pulse on a hardware level raise |
| evt_pwm_changed | output | 1 | One-cycle pulse at the end of the settle wait |

## Verification
The bound checker tests these rules on every cycle: level and width change only at a period boundary, the width never exceeds the period, a temperature-up pulse always comes with a higher level, the two events never fire together, and the held state stays quiet. Other behaviour can only be shown by the bench's scenarios. These are the exact high time measured over a period, the hysteresis band and the jumps over several levels, the exact settle delay and its restart, the clamp, and the effect of reprogrammed thresholds.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [2:0] {
    LV_OFF  = 3'd0,
    LV_Q1   = 3'd1,
    LV_HALF = 3'd2,
    LV_Q3   = 3'd3,
    LV_FULL = 3'd4
  } lvl_e;

  localparam int NUM_STEPS = 4;
  localparam int SEL_W     = 3;
endpackage

// File: rtl/fsc_pwm_core.sv
module fsc_pwm_core
  import fsc_pkg::*;
#(
  parameter int PERIOD  = 100,
  parameter int WIDTH_W = 16,
  localparam int CNT_W  = $clog2(PERIOD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               upd,
  input  logic [WIDTH_W-1:0] upd_width,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               at_end,
  output logic [WIDTH_W-1:0] width_o,
  output logic               pwm_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [WIDTH_W-1:0] width_q;

  assign at_end = run_en && (cnt_q == CNT_W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      width_q <= '0;
    end else if (!run_en) begin
      cnt_q   <= '0;
      width_q <= '0;
    end else begin
      if (at_end) begin
        cnt_q <= '0;
        if (upd) width_q <= upd_width;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign width_o = width_q;
  assign pwm_o   = WIDTH_W'(cnt_q) < width_q;
endmodule

// File: rtl/fsc_level_fsm.sv
module fsc_level_fsm
  import fsc_pkg::*;
#(
  parameter int TEMP_W    = 16,
  parameter int PERIOD    = 100,
  parameter int WIDTH_W   = 16,
  parameter int RISE_BASE = 'h3000,
  parameter int RISE_STEP = 'h2000,
  parameter int HYST_GAP  = 'h0800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               thr_we,
  input  logic [SEL_W-1:0]   thr_sel,
  input  logic [TEMP_W-1:0]  thr_data,
  input  logic [TEMP_W-1:0]  temp,
  input  logic               eval,
  output lvl_e               lvl_o,
  output logic               chg,
  output logic               up,
  output logic [WIDTH_W-1:0] tgt_width
);
  logic [TEMP_W-1:0]    rise_q [NUM_STEPS];
  logic [TEMP_W-1:0]    fall_q [NUM_STEPS];
  logic [NUM_STEPS-1:0] above;
  logic [NUM_STEPS-1:0] below;
  lvl_e                 lvl_q;
  logic [2:0]           nxt;
  logic [2:0]           up_l, dn_l;
  logic                 up_f, dn_f;

  // threshold storage: only the hard reset clears it, so it can be set while held
  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_q[g] <= TEMP_W'(RISE_BASE + g * RISE_STEP);
        fall_q[g] <= TEMP_W'(RISE_BASE + g * RISE_STEP - HYST_GAP);
      end else if (thr_we) begin
        if (thr_sel == SEL_W'(g))             rise_q[g] <= thr_data;
        if (thr_sel == SEL_W'(g + NUM_STEPS)) fall_q[g] <= thr_data;
      end
    end
    // rise_q[g] trips level g+1, fall_q[g] returns to level g
    assign above[g] = temp > rise_q[g];
    assign below[g] = temp < fall_q[g];
  end

  always_comb begin
    up_f = 1'b0;
    dn_f = 1'b0;
    up_l = 3'd0;
    dn_l = 3'd0;
    // ascending scan: the highest qualifying level is kept
    for (int k = 1; k <= NUM_STEPS; k++) begin
      if (above[k-1] && (k > int'(lvl_q))) begin
        up_f = 1'b1;
        up_l = 3'(k);
      end
    end
    // descending scan: the lowest qualifying level is kept
    for (int k = NUM_STEPS - 1; k >= 0; k--) begin
      if (below[k] && (k < int'(lvl_q))) begin
        dn_f = 1'b1;
        dn_l = 3'(k);
      end
    end
    if (up_f)      nxt = up_l;
    else if (dn_f) nxt = dn_l;
    else           nxt = lvl_q;
  end

  assign chg       = eval && (nxt != lvl_q);
  assign up        = chg && up_f;
  assign tgt_width = WIDTH_W'((int'(nxt) * PERIOD) / NUM_STEPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= LV_OFF;
    else if (!run_en) lvl_q <= LV_OFF;
    else if (chg)    lvl_q <= lvl_e'(nxt);
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/fsc_settle_timer.sv
module fsc_settle_timer #(
  parameter int SETTLE  = 1000,
  localparam int TIM_W  = $clog2(SETTLE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic start,
  output logic done
);
  logic [TIM_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_en) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt_q == TIM_W'(1)) && !start;
      if (start)              cnt_q <= TIM_W'(SETTLE);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/fan_step_ctrl.sv
module fan_step_ctrl
  import fsc_pkg::*;
#(
  parameter int TEMP_W        = 16,
  parameter int WIDTH_W       = 16,
  parameter int PWM_PERIOD    = 100,
  parameter int SETTLE_CYCLES = 500_000_000,
  parameter int RISE_BASE     = 'h3000,
  parameter int RISE_STEP     = 'h2000,
  parameter int HYST_GAP      = 'h0800,
  localparam int CNT_W        = $clog2(PWM_PERIOD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               tmp_valid,
  output logic               tmp_ready,
  input  logic [TEMP_W-1:0]  tmp_code,
  input  logic               thr_we,
  input  logic [2:0]         thr_sel,
  input  logic [TEMP_W-1:0]  thr_data,
  input  logic               wid_we,
  input  logic [WIDTH_W-1:0] wid_data,
  output logic [WIDTH_W-1:0] period_o,
  output logic [WIDTH_W-1:0] width_o,
  output logic [2:0]         level_o,
  output logic               pwm_o,
  output logic               evt_temp_up,
  output logic               evt_pwm_changed
);
  localparam logic [WIDTH_W-1:0] PER_W = WIDTH_W'(PWM_PERIOD);

  logic [TEMP_W-1:0]  temp_q;
  logic               sw_pend;
  logic [WIDTH_W-1:0] sw_val;
  logic [WIDTH_W-1:0] sw_clamped;
  logic               at_end;
  logic [CNT_W-1:0]   cnt_w;
  logic               hw_chg, hw_up;
  logic [WIDTH_W-1:0] hw_width;
  logic               upd;
  logic [WIDTH_W-1:0] upd_width;
  logic               up_q;
  lvl_e               lvl;

  assign tmp_ready = run_en;

  // sample register and software width shadow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q  <= '0;
      sw_pend <= 1'b0;
      sw_val  <= '0;
      up_q    <= 1'b0;
    end else if (!run_en) begin
      temp_q  <= '0;
      sw_pend <= 1'b0;
      sw_val  <= '0;
      up_q    <= 1'b0;
    end else begin
      if (tmp_valid) temp_q <= tmp_code;
      if (wid_we) begin
        sw_pend <= 1'b1;
        sw_val  <= wid_data;
      end else if (at_end) begin
        sw_pend <= 1'b0;
      end
      up_q <= hw_up;
    end
  end

  assign sw_clamped = (sw_val > PER_W) ? PER_W : sw_val;
  assign upd        = at_end && (sw_pend || hw_chg);
  assign upd_width  = sw_pend ? sw_clamped : hw_width;

  fsc_level_fsm #(
    .TEMP_W(TEMP_W), .PERIOD(PWM_PERIOD), .WIDTH_W(WIDTH_W),
    .RISE_BASE(RISE_BASE), .RISE_STEP(RISE_STEP), .HYST_GAP(HYST_GAP)
  ) u_lvl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_data(thr_data),
    .temp(temp_q), .eval(at_end && !sw_pend),
    .lvl_o(lvl), .chg(hw_chg), .up(hw_up), .tgt_width(hw_width)
  );

  fsc_pwm_core #(.PERIOD(PWM_PERIOD), .WIDTH_W(WIDTH_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .upd(upd), .upd_width(upd_width),
    .cnt_o(cnt_w), .at_end(at_end), .width_o(width_o), .pwm_o(pwm_o)
  );

  fsc_settle_timer #(.SETTLE(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .start(upd), .done(evt_pwm_changed)
  );

  assign period_o    = PER_W;
  assign level_o     = lvl;
  assign evt_temp_up = up_q;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int WIDTH_W = 16,
  parameter int PERIOD  = 100,
  parameter int CNT_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_en,
  input logic [2:0]         level_o,
  input logic [WIDTH_W-1:0] width_o,
  input logic               pwm_o,
  input logic               evt_temp_up,
  input logic               evt_pwm_changed,
  input logic [CNT_W-1:0]   cnt
);
  assert_held_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!pwm_o && level_o == 3'd0 && !evt_temp_up && !evt_pwm_changed));

  assert_width_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    width_o <= WIDTH_W'(PERIOD));

  assert_level_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> (cnt == '0));

  assert_width_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (width_o != $past(width_o)) |-> (cnt == '0));

  assert_up_raises_R7: assert property (@(posedge clk) disable iff (!rst_n || !run_en)
    evt_temp_up |-> (level_o > $past(level_o)));

  assert_evt_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_temp_up && evt_pwm_changed));
endmodule

bind fan_step_ctrl fsc_checker #(
  .WIDTH_W(WIDTH_W), .PERIOD(PWM_PERIOD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .level_o(level_o),
  .width_o(width_o), .pwm_o(pwm_o), .evt_temp_up(evt_temp_up),
  .evt_pwm_changed(evt_pwm_changed), .cnt(cnt_w)
);

// File: tb/sim_fan_step_ctrl.sv
module sim_fan_step_ctrl;
  localparam int P = 40;
  localparam int S = 200;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        tmp_valid = 1'b0;
  logic        tmp_ready;
  logic [15:0] tmp_code = '0;
  logic        thr_we = 1'b0;
  logic [2:0]  thr_sel = '0;
  logic [15:0] thr_data = '0;
  logic        wid_we = 1'b0;
  logic [15:0] wid_data = '0;
  logic [15:0] period_o, width_o;
  logic [2:0]  level_o;
  logic        pwm_o, evt_temp_up, evt_pwm_changed;

  int errors = 0, checks = 0;
  int cyc = 0, n_up = 0, n_chg = 0, t_up = 0, t_chg = 0;
  bit done = 1'b0;

  // {temperature code, expected level}
  localparam logic [18:0] VEC [NV] = '{
    {16'h3000, 3'd0}, {16'h3001, 3'd1}, {16'h9001, 3'd4}, {16'h8900, 3'd4},
    {16'h87FF, 3'd3}, {16'h2000, 3'd0}, {16'h5001, 3'd2}, {16'h4900, 3'd2},
    {16'h4700, 3'd1}, {16'h7001, 3'd3}
  };

  always #4 clk = ~clk;

  fan_step_ctrl #(.PWM_PERIOD(P), .SETTLE_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tmp_valid(tmp_valid),
    .tmp_ready(tmp_ready), .tmp_code(tmp_code), .thr_we(thr_we),
    .thr_sel(thr_sel), .thr_data(thr_data), .wid_we(wid_we),
    .wid_data(wid_data), .period_o(period_o), .width_o(width_o),
    .level_o(level_o), .pwm_o(pwm_o), .evt_temp_up(evt_temp_up),
    .evt_pwm_changed(evt_pwm_changed)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (evt_temp_up)     begin n_up++;  t_up  = cyc; end
    if (evt_pwm_changed) begin n_chg++; t_chg = cyc; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic high_count(output int hi);
    hi = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (pwm_o) hi++;
    end
  endtask

  task automatic send_temp(input logic [15:0] v);
    @(negedge clk); tmp_valid = 1'b1; tmp_code = v;
    @(negedge clk); tmp_valid = 1'b0;
    repeat (2 * P + 4) @(negedge clk);
  endtask

  task automatic write_width(input logic [15:0] v);
    @(negedge clk); wid_we = 1'b1; wid_data = v;
    @(negedge clk); wid_we = 1'b0;
  endtask

  task automatic write_thr(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk); thr_we = 1'b1; thr_sel = s; thr_data = v;
    @(negedge clk); thr_we = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    int hi, n0, u0c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: held while run_en low, even with a valid sample offered
    tmp_valid = 1'b1; tmp_code = 16'hFFFF;
    high_count(hi);
    chk("R1 held pwm high time", hi, 0);
    chk("R1 held level", int'(level_o), 0);
    chk("R11 ready low while held", int'(tmp_ready), 0);
    chk("R1 no events while held", n_up + n_chg, 0);
    chk("R2 period value", int'(period_o), P);
    tmp_valid = 1'b0;
    @(negedge clk); run_en = 1'b1;
    repeat (2 * P + 4) @(negedge clk);
    chk("R11 ready high when running", int'(tmp_ready), 1);
    chk("R11 unaccepted sample ignored", int'(level_o), 0);

    // R3 R4 R5: table walk with default R10 thresholds
    for (int i = 0; i < NV; i++) begin
      send_temp(VEC[i][18:3]);
      chk("R4/R5 level", int'(level_o), int'(VEC[i][2:0]));
      high_count(hi);
      chk("R3 high time", hi, int'(VEC[i][2:0]) * P / 4);
    end

    // R7 R8: rise to full, measure settle delay
    repeat (S + 2 * P) @(negedge clk);
    u0c = n_up; n0 = n_chg;
    send_temp(16'h9001);
    for (int i = 0; i < 4 * S && n_chg == n0; i++) @(negedge clk);
    chk("R7 up pulse on raise", n_up, u0c + 1);
    chk("R8 settle delay", t_chg - t_up, S);
    send_temp(16'h0000);
    chk("R5 drop to off", int'(level_o), 0);
    chk("R7 no up pulse on drop", n_up, u0c + 1);

    // R9: software width, then R2 clamp
    repeat (S + 2 * P) @(negedge clk);
    u0c = n_up; n0 = n_chg;
    write_width(16'd7);
    repeat (2 * P + 4) @(negedge clk);
    high_count(hi);
    chk("R9 software high time", hi, 7);
    chk("R9 level unchanged", int'(level_o), 0);
    repeat (S) @(negedge clk);
    chk("R9 changed event after write", n_chg, n0 + 1);
    chk("R7 no up pulse on write", n_up, u0c);
    write_width(16'd100);
    repeat (2 * P + 4) @(negedge clk);
    high_count(hi);
    chk("R2 clamp to period", hi, P);

    // R8 restart: two writes one period apart give one event
    repeat (S + 2 * P) @(negedge clk);
    n0 = n_chg;
    write_width(16'd5);
    repeat (P + 2) @(negedge clk);
    write_width(16'd9);
    repeat (2 * P) @(negedge clk);
    repeat (S + 4) @(negedge clk);
    chk("R8 restart single event", n_chg, n0 + 1);
    high_count(hi);
    chk("R9 second write high time", hi, 9);

    // R10: reprogram rising threshold of level 1 and falling threshold of level 0
    write_thr(3'd0, 16'h1000);
    write_thr(3'd4, 16'h0F00);
    send_temp(16'h1100);
    chk("R10 new rising threshold", int'(level_o), 1);
    send_temp(16'h0F80);
    chk("R10 new falling threshold holds", int'(level_o), 1);
    send_temp(16'h0E00);
    chk("R10 below new falling threshold", int'(level_o), 0);

    // R1: dropping run_en returns to the held state
    @(negedge clk); run_en = 1'b0;
    @(negedge clk);
    high_count(hi);
    chk("R1 re-held pwm", hi, 0);
    summary();
  end
endmodule